// File: doc/BRIEF.md
# Timer Compare and Soft-Interrupt Unit

This per-thread register unit keeps a free-running 63-bit tick counter and two compare channels. One channel serves the supervisor level and one serves the hypervisor level. It also holds a soft-interrupt pending register, an interrupt level register and an interrupt-enable bit. From these it tells the core whether an interrupt is pending.

Software reaches every register through one synchronous port with an address, separate read and write strobes, write data and combinational read data. A supervisor compare match latches a fixed pending bit (bit 16) in the soft-interrupt register. A hypervisor compare match latches its own request line, and that line does not touch the soft-interrupt register. Some writes can change which interrupt should be taken: soft-interrupt writes, a lower level, enabling interrupts, and timer matches. Each of these raises a one-cycle re-check strobe that tells the core to look again.

The address map is: 0 pending register, 1 set alias, 2 clear alias, 3 supervisor compare, 4 hypervisor compare, 5 interrupt level, 6 status (bit 0 = interrupt enable), 7 trap base, 8 version, 9 tick counter. Addresses 10 to 15 are unimplemented. A read of 1 or 2 returns the pending register.

Top module: `tsi_unit`

## Requirements
- R1: When tick_en is 1, the tick counter adds one on every clock and wraps from 2^63-1 to 0. When tick_en is 0, it holds its value. A write to address 9 loads bits 62:0, and this load takes priority over the increment.
- R2: A compare register is 64 bits: bits 62:0 hold the value and bit 63 is a disable flag. When the supervisor compare has bit 63 clear and its value equals the counter, pending bit 16 is set at that clock edge.
- R3: When bit 63 of a compare register is 1, that channel produces no match, even when its value equals the counter.
- R4: A hypervisor compare match sets hyp_timer_irq, which stays set until the next write to address 4. The match leaves the soft-interrupt register unchanged.
- R5: The pending register is 17 bits wide. A write to address 0 replaces it, a write to address 1 ORs the data into it, and a write to address 2 clears the bits that are 1 in the data. Each of these writes pulses recheck in the following cycle.
- R6: If a supervisor match and a clear of bit 16 happen in the same cycle, bit 16 ends up set.
- R7: recheck pulses after a level write whose 4-bit value is lower than the current level, and after a status write that changes interrupt enable from 0 to 1. A level write that is equal or higher gives no pulse, and neither does writing 1 to an enable that is already 1.
- R8: The trap base register stores the written value with bits 14:0 forced to zero, and reads of it return bits 14:0 as zero.
- R9: Address 8 reads {8'd MAX_GL, 8'd MAX_TL, 8'd NWIN} in bits 23:0 (3, 6, 8 by default). A write to it changes nothing and sets acc_err for one cycle.
- R10: A read or write at addresses 10 to 15 returns zero read data and sets acc_err for one cycle.
- R11: irq_pending is 1 only when the enable bit is 1 and some pending bit i, for i from 1 to 15, has i greater than the level. Pending bit 16 takes part in this test at level 14. Bit 0 never raises irq_pending.
- R12: After reset, the pending register, level, enable, trap base and counter are all 0. Both compare registers read 0x8000000000000000, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance enable |
| reg_addr | input | 4 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr |
| irq_pending | output | 1 | Unmasked soft interrupt above the current level |
| hyp_timer_irq | output | 1 | Latched hypervisor timer request |
| recheck | output | 1 | One-cycle interrupt re-evaluation strobe |
| acc_err | output | 1 | One-cycle illegal access flag |

## Verification
The hardest case to reach is a timer match landing in the same cycle as a software clear of bit 16, because the free-running counter hides exactly which cycle matches. The stimulus solves this by stopping the counter, loading it, and writing the compare register with the same value, which makes a match happen on every clock. It can then issue the clear and read the bit back at a known edge. The timed matches are handled the same way: the counter is stopped, loaded to a known value, and then released for an exact number of clocks. This lets the bench check the bit both one edge before the match and one edge after it.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
   localparam int ADDR_W = 4;
   localparam logic [ADDR_W-1:0] A_SOFT = 4'd0;
   localparam logic [ADDR_W-1:0] A_SSET = 4'd1;
   localparam logic [ADDR_W-1:0] A_SCLR = 4'd2;
   localparam logic [ADDR_W-1:0] A_SCMP = 4'd3;
   localparam logic [ADDR_W-1:0] A_HCMP = 4'd4;
   localparam logic [ADDR_W-1:0] A_LVL  = 4'd5;
   localparam logic [ADDR_W-1:0] A_STAT = 4'd6;
   localparam logic [ADDR_W-1:0] A_TBA  = 4'd7;
   localparam logic [ADDR_W-1:0] A_VER  = 4'd8;
   localparam logic [ADDR_W-1:0] A_TICK = 4'd9;
   localparam logic [ADDR_W-1:0] A_LAST = A_TICK;
   localparam int N_CMP = 2;
   localparam int CH_SUP = 0;
   localparam int CH_HYP = 1;
endpackage

// File: rtl/tsi_tick_ctr.sv
module tsi_tick_ctr #(
   parameter int TICK_W = 63
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              ld,
   input  logic [TICK_W-1:0] ld_val,
   output logic [TICK_W-1:0] cnt
);
   localparam logic [TICK_W-1:0] ONE = TICK_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)   cnt <= '0;
      else if (ld)  cnt <= ld_val;
      else if (en)  cnt <= cnt + ONE;
   end

   // R1: advance by one with wrap when enabled and not loaded
   a_r1_tick_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !ld) |=> cnt == $past(cnt) + ONE);
   a_r1_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !ld) |=> $stable(cnt));
endmodule

// File: rtl/tsi_cmp.sv
module tsi_cmp #(
   parameter int TICK_W = 63
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [TICK_W:0]   wdata,
   input  logic [TICK_W-1:0] tick,
   output logic [TICK_W:0]   cmp_q,
   output logic              hit
);
   localparam logic [TICK_W:0] RST_VAL = {1'b1, {TICK_W{1'b0}}};

   always_ff @(posedge clk) begin
      if (!rst_n)  cmp_q <= RST_VAL;
      else if (wr) cmp_q <= wdata;
   end

   always_comb hit = !cmp_q[TICK_W] && (cmp_q[TICK_W-1:0] == tick);

   // R2: a write lands in the compare register whole
   a_r2_cmp_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> cmp_q == $past(wdata));
endmodule

// File: rtl/tsi_softint.sv
module tsi_softint #(
   parameter int SOFT_W  = 17,
   parameter int TMR_BIT = 16,
   parameter int LVL_W   = 4,
   parameter int TMR_LVL = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_direct,
   input  logic              wr_set,
   input  logic              wr_clr,
   input  logic [SOFT_W-1:0] wdata,
   input  logic              hw_set,
   input  logic [LVL_W-1:0]  lvl,
   input  logic              ie,
   output logic [SOFT_W-1:0] soft_q,
   output logic              pend
);
   localparam int N_LVL = 1 << LVL_W;

   logic [SOFT_W-1:0] soft_d;
   logic [SOFT_W-1:0] above;

   always_comb begin
      soft_d = soft_q;
      if (wr_direct)   soft_d = wdata;
      else if (wr_set) soft_d = soft_q | wdata;
      else if (wr_clr) soft_d = soft_q & ~wdata;
      if (hw_set)      soft_d[TMR_BIT] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) soft_q <= '0;
      else        soft_q <= soft_d;
   end

   assign above[0] = 1'b0;
   for (genvar i = 1; i < SOFT_W; i++) begin : g_lvl
      if (i == TMR_BIT) begin : g_tmr
         localparam logic [LVL_W-1:0] LV = LVL_W'(TMR_LVL);
         assign above[i] = soft_q[i] && (LV > lvl);
      end else if (i < N_LVL) begin : g_sw
         localparam logic [LVL_W-1:0] LV = LVL_W'(i);
         assign above[i] = soft_q[i] && (LV > lvl);
      end else begin : g_none
         assign above[i] = 1'b0;
      end
   end

   always_comb pend = ie && (|above);

   // R6: a timer match beats any software update of the same bit
   a_r6_match_wins: assert property (@(posedge clk) disable iff (!rst_n)
      hw_set |=> soft_q[TMR_BIT]);
   // R5: set alias only adds bits
   a_r5_set_or: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_set && !wr_direct) |=> (soft_q & $past(wdata)) == $past(wdata));
   // R5: clear alias removes the selected bits
   a_r5_clr_andn: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clr && !wr_direct && !wr_set && !hw_set) |=> (soft_q & $past(wdata)) == '0);
endmodule

// File: rtl/tsi_unit.sv
module tsi_unit
   import tsi_pkg::*;
#(
   parameter int DATA_W  = 64,
   parameter int TICK_W  = 63,
   parameter int SOFT_W  = 17,
   parameter int TMR_BIT = 16,
   parameter int LVL_W   = 4,
   parameter int TMR_LVL = 14,
   parameter int TBA_LOW = 15,
   parameter int NWIN    = 8,
   parameter int MAX_TL  = 6,
   parameter int MAX_GL  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [3:0]        reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_pending,
   output logic              hyp_timer_irq,
   output logic              recheck,
   output logic              acc_err
);
   localparam int CMP_W = TICK_W + 1;
   localparam logic [DATA_W-1:0] TBA_MASK = ~((DATA_W'(1) << TBA_LOW) - DATA_W'(1));
   localparam logic [DATA_W-1:0] VER_VAL =
      DATA_W'({8'(MAX_GL), 8'(MAX_TL), 8'(NWIN)});

   if (DATA_W < CMP_W) begin : g_chk_w
      $error("DATA_W must hold a full compare register");
   end
   if (DATA_W < 24) begin : g_chk_v
      $error("DATA_W must hold the version fields");
   end
   if (TMR_BIT >= SOFT_W || TMR_BIT < 1) begin : g_chk_t
      $error("TMR_BIT must lie inside the pending register");
   end
   if (TMR_LVL >= (1 << LVL_W)) begin : g_chk_l
      $error("TMR_LVL must fit LVL_W");
   end
   if (TBA_LOW < 1 || TBA_LOW >= DATA_W) begin : g_chk_b
      $error("TBA_LOW out of range");
   end

   // decode
   logic impl, w_soft, w_sset, w_sclr, w_lvl, w_stat, w_tba, w_tick, w_ver;
   logic [N_CMP-1:0] w_cmp;
   always_comb begin
      impl   = (reg_addr <= A_LAST);
      w_soft = reg_wr && (reg_addr == A_SOFT);
      w_sset = reg_wr && (reg_addr == A_SSET);
      w_sclr = reg_wr && (reg_addr == A_SCLR);
      w_lvl  = reg_wr && (reg_addr == A_LVL);
      w_stat = reg_wr && (reg_addr == A_STAT);
      w_tba  = reg_wr && (reg_addr == A_TBA);
      w_tick = reg_wr && (reg_addr == A_TICK);
      w_ver  = reg_wr && (reg_addr == A_VER);
      w_cmp[CH_SUP] = reg_wr && (reg_addr == A_SCMP);
      w_cmp[CH_HYP] = reg_wr && (reg_addr == A_HCMP);
   end

   // counter
   logic [TICK_W-1:0] tick;
   tsi_tick_ctr #(.TICK_W(TICK_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .en(tick_en), .ld(w_tick),
      .ld_val(reg_wdata[TICK_W-1:0]), .cnt(tick));

   // compare channels
   logic [CMP_W-1:0] cmp_q [N_CMP];
   logic [N_CMP-1:0] hit;
   for (genvar c = 0; c < N_CMP; c++) begin : g_cmp
      tsi_cmp #(.TICK_W(TICK_W)) u_cmp (
         .clk(clk), .rst_n(rst_n), .wr(w_cmp[c]),
         .wdata(reg_wdata[CMP_W-1:0]), .tick(tick),
         .cmp_q(cmp_q[c]), .hit(hit[c]));
   end

   // control registers
   logic [LVL_W-1:0]  lvl_q;
   logic              ie_q;
   logic [DATA_W-1:0] tba_q;
   logic              rck_d, err_d;

   always_comb begin
      rck_d = w_soft || w_sset || w_sclr || (|hit)
            || (w_lvl && (reg_wdata[LVL_W-1:0] < lvl_q))
            || (w_stat && reg_wdata[0] && !ie_q);
      err_d = ((reg_wr || reg_rd) && !impl) || w_ver;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q         <= '0;
         ie_q          <= 1'b0;
         tba_q         <= '0;
         hyp_timer_irq <= 1'b0;
         recheck       <= 1'b0;
         acc_err       <= 1'b0;
      end else begin
         if (w_lvl)  lvl_q <= reg_wdata[LVL_W-1:0];
         if (w_stat) ie_q  <= reg_wdata[0];
         if (w_tba)  tba_q <= reg_wdata & TBA_MASK;
         if (hit[CH_HYP])      hyp_timer_irq <= 1'b1;
         else if (w_cmp[CH_HYP]) hyp_timer_irq <= 1'b0;
         recheck <= rck_d;
         acc_err <= err_d;
      end
   end

   // pending register
   logic [SOFT_W-1:0] soft_q;
   tsi_softint #(.SOFT_W(SOFT_W), .TMR_BIT(TMR_BIT), .LVL_W(LVL_W), .TMR_LVL(TMR_LVL)) u_soft (
      .clk(clk), .rst_n(rst_n), .wr_direct(w_soft), .wr_set(w_sset),
      .wr_clr(w_sclr), .wdata(reg_wdata[SOFT_W-1:0]), .hw_set(hit[CH_SUP]),
      .lvl(lvl_q), .ie(ie_q), .soft_q(soft_q), .pend(irq_pending));

   // read mux
   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_SOFT, A_SSET, A_SCLR: reg_rdata[SOFT_W-1:0] = soft_q;
         A_SCMP: reg_rdata[CMP_W-1:0] = cmp_q[CH_SUP];
         A_HCMP: reg_rdata[CMP_W-1:0] = cmp_q[CH_HYP];
         A_LVL:  reg_rdata[LVL_W-1:0] = lvl_q;
         A_STAT: reg_rdata[0]         = ie_q;
         A_TBA:  reg_rdata            = tba_q & TBA_MASK;
         A_VER:  reg_rdata            = VER_VAL;
         A_TICK: reg_rdata[TICK_W-1:0] = tick;
         default: reg_rdata = '0;
      endcase
   end

   // R3: a disabled supervisor compare cannot disturb the timer bit
   a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_q[CH_SUP][TICK_W] && !w_soft && !w_sset && !w_sclr)
      |=> soft_q[TMR_BIT] == $past(soft_q[TMR_BIT]));
   // R4: hypervisor request is sticky until its compare is rewritten
   a_r4_hyp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (hyp_timer_irq && !w_cmp[CH_HYP]) |=> hyp_timer_irq);
   // R7: a lowered level always requests re-evaluation
   a_r7_lower_lvl: assert property (@(posedge clk) disable iff (!rst_n)
      (w_lvl && (reg_wdata[LVL_W-1:0] < lvl_q)) |=> recheck);
   // R8: trap base low bits never hold ones
   a_r8_tba_low: assert property (@(posedge clk) disable iff (!rst_n)
      tba_q[TBA_LOW-1:0] == '0);
   // R9: version writes are flagged
   a_r9_ver_flag: assert property (@(posedge clk) disable iff (!rst_n)
      w_ver |=> acc_err);
   // R10: holes read as zero
   a_r10_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr > A_LAST) |-> reg_rdata == '0);
endmodule

// File: tb/tb_tsi_unit.sv
`timescale 1ns/1ps
module tb_tsi_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic        irq_pending, hyp_timer_irq, recheck, acc_err;

   int n_chk = 0;
   int n_bad = 0;
   logic [63:0] last_rd;
   bit done = 0;

   always #10 clk = ~clk;

   tsi_unit dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_pending(irq_pending),
      .hyp_timer_irq(hyp_timer_irq), .recheck(recheck), .acc_err(acc_err));

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic acc(input logic wr, input logic [3:0] a, input logic [63:0] d);
      reg_addr = a; reg_wr = wr; reg_rd = !wr; reg_wdata = d;
      #1 last_rd = reg_rdata;
      @(negedge clk);
      reg_wr = 1'b0; reg_rd = 1'b0;
   endtask

   typedef struct packed {
      logic        wr;
      logic [3:0]  a;
      logic [63:0] d;
      logic [63:0] exp;
      logic        err;
      logic        rck;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 4'd0, 64'h0A5,   64'h0,   1'b0, 1'b1},  // R5 direct
      '{1'b0, 4'd0, 64'h0,     64'h0A5, 1'b0, 1'b0},
      '{1'b1, 4'd1, 64'h10300, 64'h0,   1'b0, 1'b1},  // R5 set
      '{1'b0, 4'd0, 64'h0,     64'h103A5, 1'b0, 1'b0},
      '{1'b1, 4'd2, 64'h00125, 64'h0,   1'b0, 1'b1},  // R5 clear
      '{1'b0, 4'd1, 64'h0,     64'h10280, 1'b0, 1'b0},
      '{1'b1, 4'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0, 1'b0}, // R8
      '{1'b0, 4'd7, 64'h0,     64'hFFFF_FFFF_FFFF_8000, 1'b0, 1'b0},
      '{1'b0, 4'd8, 64'h0,     64'h030608, 1'b0, 1'b0}, // R9
      '{1'b1, 4'd8, 64'h1234,  64'h0,   1'b1, 1'b0},
      '{1'b0, 4'd8, 64'h0,     64'h030608, 1'b0, 1'b0},
      '{1'b0, 4'd12, 64'h0,    64'h0,   1'b1, 1'b0},  // R10
      '{1'b1, 4'd15, 64'h55,   64'h0,   1'b1, 1'b0},
      '{1'b1, 4'd5, 64'h5,     64'h0,   1'b0, 1'b0},  // R7 raise
      '{1'b1, 4'd5, 64'h3,     64'h0,   1'b0, 1'b1},  // R7 lower
      '{1'b1, 4'd5, 64'h3,     64'h0,   1'b0, 1'b0},  // R7 equal
      '{1'b0, 4'd5, 64'h0,     64'h3,   1'b0, 1'b0},
      '{1'b1, 4'd6, 64'h1,     64'h0,   1'b0, 1'b1},  // R7 enable 0->1
      '{1'b1, 4'd6, 64'h1,     64'h0,   1'b0, 1'b0},  // R7 enable 1->1
      '{1'b0, 4'd6, 64'h0,     64'h1,   1'b0, 1'b0}
   };

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      chk({irq_pending, hyp_timer_irq, recheck, acc_err} == 4'b0, "R12 outputs",
          64'({irq_pending, hyp_timer_irq, recheck, acc_err}), 64'h0);
      acc(1'b0, 4'd0, '0); chk(last_rd == 64'h0, "R12 pending", last_rd, 64'h0);
      acc(1'b0, 4'd3, '0); chk(last_rd == 64'h8000_0000_0000_0000, "R12 sup cmp", last_rd, 64'h8000_0000_0000_0000);
      acc(1'b0, 4'd4, '0); chk(last_rd == 64'h8000_0000_0000_0000, "R12 hyp cmp", last_rd, 64'h8000_0000_0000_0000);
      acc(1'b0, 4'd9, '0); chk(last_rd == 64'h0, "R12 tick", last_rd, 64'h0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         acc(VEC[i].wr, VEC[i].a, VEC[i].d);
         if (!VEC[i].wr)
            chk(last_rd == VEC[i].exp, $sformatf("R5/R7/R8/R9/R10 vec %0d rdata", i), last_rd, VEC[i].exp);
         chk(acc_err == VEC[i].err, $sformatf("R9/R10 vec %0d acc_err", i), 64'(acc_err), 64'(VEC[i].err));
         chk(recheck == VEC[i].rck, $sformatf("R5/R7 vec %0d recheck", i), 64'(recheck), 64'(VEC[i].rck));
      end

      // R11: pending 0x10280, level 3, enabled
      chk(irq_pending == 1'b1, "R11 bits above level", 64'(irq_pending), 64'h1);
      acc(1'b1, 4'd5, 64'hF);
      chk(irq_pending == 1'b0, "R11 level 15 masks all", 64'(irq_pending), 64'h0);
      acc(1'b1, 4'd5, 64'hD);
      chk(irq_pending == 1'b1, "R11 timer bit at level 14", 64'(irq_pending), 64'h1);
      acc(1'b1, 4'd6, 64'h0);
      chk(irq_pending == 1'b0, "R11 disabled", 64'(irq_pending), 64'h0);
      acc(1'b1, 4'd6, 64'h1);
      acc(1'b1, 4'd5, 64'h0);
      acc(1'b1, 4'd0, 64'h1);
      chk(irq_pending == 1'b0, "R11 bit0 ignored", 64'(irq_pending), 64'h0);
      acc(1'b1, 4'd0, 64'h0);

      // R1 wrap and hold
      tick_en = 1'b1;
      acc(1'b1, 4'd9, 64'h7FFF_FFFF_FFFF_FFFF);
      acc(1'b0, 4'd9, '0); chk(last_rd == 64'h7FFF_FFFF_FFFF_FFFF, "R1 load", last_rd, 64'h7FFF_FFFF_FFFF_FFFF);
      acc(1'b0, 4'd9, '0); chk(last_rd == 64'h0, "R1 wrap", last_rd, 64'h0);
      tick_en = 1'b0;
      acc(1'b0, 4'd9, '0); chk(last_rd == 64'h1, "R1 advance", last_rd, 64'h1);
      acc(1'b0, 4'd9, '0); chk(last_rd == 64'h1, "R1 hold", last_rd, 64'h1);

      // R2 supervisor match timing
      acc(1'b1, 4'd9, 64'd1000);
      acc(1'b1, 4'd3, 64'd1004);
      tick_en = 1'b1;
      repeat (3) @(negedge clk);
      acc(1'b0, 4'd0, '0);
      chk(last_rd[16] == 1'b0, "R2 before match", 64'(last_rd[16]), 64'h0);
      @(negedge clk);
      tick_en = 1'b0;
      acc(1'b0, 4'd0, '0);
      chk(last_rd[16] == 1'b1, "R2 after match", 64'(last_rd[16]), 64'h1);

      // R3 disabled compare at the counter value
      acc(1'b1, 4'd0, 64'h0);
      acc(1'b1, 4'd9, 64'd2000);
      acc(1'b1, 4'd3, 64'h8000_0000_0000_07D0);
      repeat (3) @(negedge clk);
      acc(1'b0, 4'd0, '0);
      chk(last_rd == 64'h0, "R3 no match when disabled", last_rd, 64'h0);

      // R6 match beats same-cycle clear
      acc(1'b1, 4'd9, 64'd3000);
      acc(1'b1, 4'd3, 64'd3000);
      acc(1'b1, 4'd2, 64'h10000);
      acc(1'b0, 4'd0, '0);
      chk(last_rd[16] == 1'b1, "R6 match wins", 64'(last_rd[16]), 64'h1);
      acc(1'b1, 4'd3, 64'h8000_0000_0000_0000);
      acc(1'b1, 4'd2, 64'h10000);
      acc(1'b0, 4'd0, '0);
      chk(last_rd == 64'h0, "R6 clear once idle", last_rd, 64'h0);

      // R4 hypervisor match
      acc(1'b1, 4'd9, 64'd500);
      acc(1'b1, 4'd4, 64'd503);
      chk(hyp_timer_irq == 1'b0, "R4 before match", 64'(hyp_timer_irq), 64'h0);
      tick_en = 1'b1;
      repeat (5) @(negedge clk);
      tick_en = 1'b0;
      chk(hyp_timer_irq == 1'b1, "R4 raised", 64'(hyp_timer_irq), 64'h1);
      acc(1'b0, 4'd0, '0);
      chk(last_rd == 64'h0, "R4 pending untouched", last_rd, 64'h0);
      chk(hyp_timer_irq == 1'b1, "R4 sticky", 64'(hyp_timer_irq), 64'h1);
      acc(1'b1, 4'd4, 64'h8000_0000_0000_0000);
      chk(hyp_timer_irq == 1'b0, "R4 cleared by write", 64'(hyp_timer_irq), 64'h0);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule